// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block drives a single chip-select space of an asynchronous SRAM or flash-style device from one synchronous clock. A client raises a request carrying a direction bit, an address, byte enables and write data, and holds it until the block answers with a one-cycle acknowledge. Between those two events the block walks the memory pins through three phases. In the setup phase the selects are valid and the strobes are idle. In the strobe phase the read or write strobe is active. In the hold phase the selects stay valid after the strobe has been released.

Reads and writes each have their own setup, strobe and hold lengths. Every length is a count of clock periods, and a programmed zero acts as one. A ready input from the device is brought through a synchronizer, and a low ready keeps the strobe phase running past its programmed length. Read data is captured on the clock edge that releases the read strobe, and it is returned alongside the acknowledge.

Top module: `asram_seq`

## Requirements
- R1: After reset, chip select, output enable, read strobe and write strobe are all high (inactive), the data driver enable and the acknowledge are low.
- R2: The setup phase lasts max(1, S) cycles, where S is the setup field of the access direction. During this phase chip select is low and both strobes are high.
- R3: With ready held high, the strobe phase lasts max(1, T) cycles, where T is the strobe field of the access direction. The read strobe is low for reads, the write strobe is low for writes, and the other strobe stays high.
- R4: The hold phase lasts max(1, H) cycles, where H is the hold field of the access direction. During this phase chip select stays low and both strobes are high.
- R5: Reads use only the three read fields and writes use only the three write fields. Changing the fields of the other direction has no effect on an access.
- R6: Output enable is low in every cycle of a read in which chip select is low, and it stays high throughout a write. The data driver enable is high in every cycle of a write in which chip select is low, and it is low otherwise.
- R7: Address, active-low byte enables (the inverse of the requested enables) and write data are taken when the request is accepted and held for the whole access. Changes on the request inputs while the block is busy are ignored.
- R8: Ready passes through two synchronizing flip-flops, and the strobe phase can only end in a cycle where the synchronized ready is high. Suppose ready is low when the access starts and is raised just after the j-th strobe cycle. The strobe phase then lasts max(T', j+2) cycles, where T' = max(1, T).
- R9: The read data bus is sampled on the edge that ends the read strobe phase. That value appears on the response output in the acknowledge cycle.
- R10: The acknowledge is high for exactly one cycle, in the cycle after the hold phase. Chip select is high in that cycle and in the cycle after it, and no request is accepted until the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_be | input | BEW | Byte enables, active high |
| req_wdata | input | DW | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Captured read data |
| cfg_rd_setup | input | SETUP_W | Read setup length |
| cfg_rd_strobe | input | STROBE_W | Read strobe length |
| cfg_rd_hold | input | HOLD_W | Read hold length |
| cfg_wr_setup | input | SETUP_W | Write setup length |
| cfg_wr_strobe | input | STROBE_W | Write strobe length |
| cfg_wr_hold | input | HOLD_W | Write hold length |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_addr | output | AW | Address to the device |
| mem_be_n | output | BEW | Byte enables, active low |
| mem_dout | output | DW | Write data to the device |
| mem_dout_en | output | 1 | Data driver enable |
| mem_din | input | DW | Read data from the device |
| mem_rdy_async | input | 1 | Device ready, asynchronous |

## Verification
The bench sweeps every combination of setup, strobe and hold from 0 to 3, in both directions, and measures the length of each phase at the pins. It also runs the maximum field values. A design that ignored the zero-as-one rule would lose a phase entirely, and a design that mixed up the read and write fields would show the other direction's deliberately distinct lengths. In the ready tests, ready is released at chosen strobe cycles, and the bench expects exactly two extra synchronizer cycles. A synchronizer of the wrong depth, or a counter that ends the strobe while ready is low, changes that count. The device model drives valid read data only while the read strobe is low, so a design that captured late would return garbage. The request inputs are scrambled during each access, so a design that accepted them while busy would move its address or data mid-cycle.

// File: rtl/asram_seq_pkg.sv
package asram_seq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_SETUP  = 3'd1,
      PH_STROBE = 3'd2,
      PH_HOLD   = 3'd3,
      PH_DONE   = 3'd4
   } phase_e;

endpackage

// File: rtl/asram_rdy_sync.sv
module asram_rdy_sync #(
   parameter int          STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rdy_async,
   output logic rdy_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("asram_rdy_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q <= {stg_q[STAGES-2:0], rdy_async};
      end
   end

   assign rdy_sync = stg_q[STAGES-1];

endmodule

// File: rtl/asram_phase_ctrl.sv
module asram_phase_ctrl
   import asram_seq_pkg::*;
#(
   parameter int SETUP_W  = 4,
   parameter int STROBE_W = 6,
   parameter int HOLD_W   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                start_write,
   input  logic [SETUP_W-1:0]  rd_setup,
   input  logic [STROBE_W-1:0] rd_strobe,
   input  logic [HOLD_W-1:0]   rd_hold,
   input  logic [SETUP_W-1:0]  wr_setup,
   input  logic [STROBE_W-1:0] wr_strobe,
   input  logic [HOLD_W-1:0]   wr_hold,
   input  logic                rdy_sync,
   output phase_e              phase,
   output logic                is_write,
   output logic                fire
);

   localparam int CW_SH = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
   localparam int CW    = (CW_SH > STROBE_W) ? CW_SH : STROBE_W;

   if (SETUP_W < 1 || STROBE_W < 1 || HOLD_W < 1) begin : g_bad_width
      $error("asram_phase_ctrl: field widths must be at least 1");
   end

   function automatic logic [CW-1:0] load_val(input logic [CW-1:0] n);
      return (n == '0) ? '0 : n - 1'b1;
   endfunction

   phase_e         phase_q;
   logic           wr_q;
   logic [CW-1:0]  cnt_q;
   logic           cnt_zero;
   logic [CW-1:0]  setup_sel;
   logic [CW-1:0]  strobe_sel;
   logic [CW-1:0]  hold_sel;

   assign setup_sel  = start_write ? CW'(wr_setup)  : CW'(rd_setup);
   assign strobe_sel = wr_q        ? CW'(wr_strobe) : CW'(rd_strobe);
   assign hold_sel   = wr_q        ? CW'(wr_hold)   : CW'(rd_hold);
   assign cnt_zero   = (cnt_q == '0);
   assign fire       = (phase_q == PH_STROBE) && cnt_zero && rdy_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         cnt_q   <= '0;
      end else begin
         unique case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_SETUP;
                  wr_q    <= start_write;
                  cnt_q   <= load_val(setup_sel);
               end
            end
            PH_SETUP: begin
               if (cnt_zero) begin
                  phase_q <= PH_STROBE;
                  cnt_q   <= load_val(strobe_sel);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_STROBE: begin
               if (!cnt_zero) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (rdy_sync) begin
                  phase_q <= PH_HOLD;
                  cnt_q   <= load_val(hold_sel);
               end
            end
            PH_HOLD: begin
               if (cnt_zero) begin
                  phase_q <= PH_DONE;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            PH_DONE: begin
               phase_q <= PH_IDLE;
            end
            default: begin
               phase_q <= PH_IDLE;
            end
         endcase
      end
   end

   assign phase    = phase_q;
   assign is_write = wr_q;

   // R8: strobe cannot end while synchronized ready is low
   assert_strobe_waits_rdy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_STROBE && !rdy_sync) |=> (phase_q == PH_STROBE));

   // R10: completion cycle always returns to idle
   assert_done_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DONE) |=> (phase_q == PH_IDLE));

   // R7: direction is frozen while an access runs
   assert_dir_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |-> $stable(wr_q));

endmodule

// File: rtl/asram_bus_regs.sv
module asram_bus_regs
   import asram_seq_pkg::*;
#(
   parameter int AW  = 20,
   parameter int DW  = 32,
   parameter int BEW = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [AW-1:0]  req_addr,
   input  logic [BEW-1:0] req_be,
   input  logic [DW-1:0]  req_wdata,
   input  phase_e         phase,
   input  logic           is_write,
   input  logic           fire,
   input  logic [DW-1:0]  mem_din,
   output logic [DW-1:0]  rsp_rdata,
   output logic           mem_cs_n,
   output logic           mem_oe_n,
   output logic           mem_re_n,
   output logic           mem_we_n,
   output logic [AW-1:0]  mem_addr,
   output logic [BEW-1:0] mem_be_n,
   output logic [DW-1:0]  mem_dout,
   output logic           mem_dout_en
);

   logic [AW-1:0]  addr_q;
   logic [BEW-1:0] be_q;
   logic [DW-1:0]  wdata_q;
   logic [DW-1:0]  rdata_q;
   logic           busy;
   logic           strobing;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         be_q    <= '0;
         wdata_q <= '0;
      end else if (start) begin
         addr_q  <= req_addr;
         be_q    <= req_be;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (fire && !is_write) begin
         rdata_q <= mem_din;
      end
   end

   assign busy     = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
   assign strobing = (phase == PH_STROBE);

   assign mem_cs_n    = !busy;
   assign mem_oe_n    = !(busy && !is_write);
   assign mem_re_n    = !(strobing && !is_write);
   assign mem_we_n    = !(strobing && is_write);
   assign mem_addr    = addr_q;
   assign mem_be_n    = busy ? ~be_q : {BEW{1'b1}};
   assign mem_dout    = wdata_q;
   assign mem_dout_en = busy && is_write;
   assign rsp_rdata   = rdata_q;

   // R6: never both strobes at once
   assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_re_n && !mem_we_n));

   // R6: output enable is off whenever write strobe is on
   assert_oe_off_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   // R7: address stays put across consecutive busy cycles
   assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: rtl/asram_seq.sv
module asram_seq
   import asram_seq_pkg::*;
#(
   parameter int AW          = 20,
   parameter int DW          = 32,
   parameter int SETUP_W     = 4,
   parameter int STROBE_W    = 6,
   parameter int HOLD_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter int BEW         = DW / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [AW-1:0]       req_addr,
   input  logic [BEW-1:0]      req_be,
   input  logic [DW-1:0]       req_wdata,
   output logic                req_ack,
   output logic [DW-1:0]       rsp_rdata,
   input  logic [SETUP_W-1:0]  cfg_rd_setup,
   input  logic [STROBE_W-1:0] cfg_rd_strobe,
   input  logic [HOLD_W-1:0]   cfg_rd_hold,
   input  logic [SETUP_W-1:0]  cfg_wr_setup,
   input  logic [STROBE_W-1:0] cfg_wr_strobe,
   input  logic [HOLD_W-1:0]   cfg_wr_hold,
   output logic                mem_cs_n,
   output logic                mem_oe_n,
   output logic                mem_re_n,
   output logic                mem_we_n,
   output logic [AW-1:0]       mem_addr,
   output logic [BEW-1:0]      mem_be_n,
   output logic [DW-1:0]       mem_dout,
   output logic                mem_dout_en,
   input  logic [DW-1:0]       mem_din,
   input  logic                mem_rdy_async
);

   if (DW % 8 != 0 || BEW != DW / 8) begin : g_bad_dw
      $error("asram_seq: DW must be a multiple of 8 and BEW must equal DW/8");
   end
   if (AW < 1) begin : g_bad_aw
      $error("asram_seq: AW must be at least 1");
   end

   phase_e phase;
   logic   is_write;
   logic   fire;
   logic   rdy_sync;
   logic   start;

   assign start   = req_valid && (phase == PH_IDLE);
   assign req_ack = (phase == PH_DONE);

   asram_rdy_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) u_rdy_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .rdy_async (mem_rdy_async),
      .rdy_sync  (rdy_sync)
   );

   asram_phase_ctrl #(
      .SETUP_W  (SETUP_W),
      .STROBE_W (STROBE_W),
      .HOLD_W   (HOLD_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .start_write (req_write),
      .rd_setup    (cfg_rd_setup),
      .rd_strobe   (cfg_rd_strobe),
      .rd_hold     (cfg_rd_hold),
      .wr_setup    (cfg_wr_setup),
      .wr_strobe   (cfg_wr_strobe),
      .wr_hold     (cfg_wr_hold),
      .rdy_sync    (rdy_sync),
      .phase       (phase),
      .is_write    (is_write),
      .fire        (fire)
   );

   asram_bus_regs #(
      .AW  (AW),
      .DW  (DW),
      .BEW (BEW)
   ) u_bus (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .req_addr    (req_addr),
      .req_be      (req_be),
      .req_wdata   (req_wdata),
      .phase       (phase),
      .is_write    (is_write),
      .fire        (fire),
      .mem_din     (mem_din),
      .rsp_rdata   (rsp_rdata),
      .mem_cs_n    (mem_cs_n),
      .mem_oe_n    (mem_oe_n),
      .mem_re_n    (mem_re_n),
      .mem_we_n    (mem_we_n),
      .mem_addr    (mem_addr),
      .mem_be_n    (mem_be_n),
      .mem_dout    (mem_dout),
      .mem_dout_en (mem_dout_en)
   );

   // R10: acknowledge is a single-cycle pulse
   assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   // R10: chip select is released in the acknowledge cycle
   assert_cs_off_at_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |-> mem_cs_n);

endmodule

// File: tb/asram_seq_tb.sv
module asram_seq_tb;

   localparam int CLK_PERIOD = 10;
   localparam int AW  = 20;
   localparam int DW  = 32;
   localparam int BEW = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req_valid = 1'b0;
   logic           req_write = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [BEW-1:0] req_be = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic           req_ack;
   logic [DW-1:0]  rsp_rdata;
   logic [3:0]     cfg_rd_setup = '0;
   logic [5:0]     cfg_rd_strobe = '0;
   logic [2:0]     cfg_rd_hold = '0;
   logic [3:0]     cfg_wr_setup = '0;
   logic [5:0]     cfg_wr_strobe = '0;
   logic [2:0]     cfg_wr_hold = '0;
   logic           mem_cs_n, mem_oe_n, mem_re_n, mem_we_n, mem_dout_en;
   logic [AW-1:0]  mem_addr;
   logic [BEW-1:0] mem_be_n;
   logic [DW-1:0]  mem_dout;
   logic [DW-1:0]  mem_din;
   logic           mem_rdy_async = 1'b1;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [DW-1:0] dev_word(input logic [AW-1:0] a);
      return {a[15:0] ^ 16'hA5C3, ~a[15:0]};
   endfunction

   // device model: data valid only while the read strobe is low
   always_comb mem_din = !mem_re_n ? dev_word(mem_addr) : 32'hDEAD_BEEF;

   asram_seq u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack), .rsp_rdata(rsp_rdata),
      .cfg_rd_setup(cfg_rd_setup), .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
      .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe), .cfg_wr_hold(cfg_wr_hold),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_be_n(mem_be_n), .mem_dout(mem_dout),
      .mem_dout_en(mem_dout_en), .mem_din(mem_din), .mem_rdy_async(mem_rdy_async)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int eff(input int n);
      return (n == 0) ? 1 : n;
   endfunction

   // rel_j > 0: ready is low at start and raised after the rel_j-th strobe cycle
   task automatic run_access(input bit wr, input logic [AW-1:0] a, input logic [BEW-1:0] be,
                             input logic [DW-1:0] wd, input int exp_s, input int exp_t,
                             input int exp_h, input int rel_j, input string tag);
      int n_s = 0, n_t = 0, n_h = 0, bad = 0, iter = 0;
      bit seen_t = 0, got_ack = 0;
      @(negedge clk);
      req_write = wr; req_addr = a; req_be = be; req_wdata = wd; req_valid = 1'b1;
      if (rel_j > 0) mem_rdy_async = 1'b0;
      while (!got_ack && iter < 400) begin
         @(negedge clk);
         iter++;
         if (req_ack) begin
            got_ack = 1;
            check(mem_cs_n == 1'b1, "R10", {tag, " cs high at ack"}, mem_cs_n, 1);
            if (!wr) check(rsp_rdata == dev_word(a), "R9", {tag, " read data"},
                           rsp_rdata, dev_word(a));
         end else if (!mem_cs_n) begin
            if (mem_addr != a || mem_be_n != ~be) bad++;
            if (mem_oe_n != wr || mem_dout_en != wr) bad++;
            if (wr && mem_dout != wd) bad++;
            if ((wr ? mem_re_n : mem_we_n) != 1'b1) bad++;
            if ((wr ? mem_we_n : mem_re_n) == 1'b0) begin
               n_t++; seen_t = 1;
            end else if (!seen_t) n_s++;
            else n_h++;
            // R7: scramble request inputs while busy
            req_addr = ~a; req_be = ~be; req_wdata = ~wd; req_write = ~wr;
            if (rel_j > 0 && n_t == rel_j && mem_rdy_async == 1'b0) mem_rdy_async = 1'b1;
         end
      end
      req_valid = 1'b0;
      mem_rdy_async = 1'b1;
      check(got_ack, "R10", {tag, " ack seen"}, got_ack, 1);
      check(n_s == exp_s, "R2", {tag, " setup cycles"}, n_s, exp_s);
      check(n_t == exp_t, (rel_j > 0) ? "R8" : "R3", {tag, " strobe cycles"}, n_t, exp_t);
      check(n_h == exp_h, "R4", {tag, " hold cycles"}, n_h, exp_h);
      check(bad == 0, "R6/R7", {tag, " select signal errors"}, bad, 0);
      @(negedge clk);
      check(!req_ack && mem_cs_n, "R10", {tag, " ack single cycle, idle gap"},
            {req_ack, mem_cs_n}, 2'b01);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(mem_cs_n && mem_oe_n && mem_re_n && mem_we_n && !mem_dout_en && !req_ack,
            "R1", "reset outputs",
            {mem_cs_n, mem_oe_n, mem_re_n, mem_we_n, mem_dout_en, req_ack}, 6'b111100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 R3 R4 R5: sweep of read fields, write fields set to distinct values
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < 4; t++)
            for (int h = 0; h < 4; h++) begin
               cfg_rd_setup = 4'(s); cfg_rd_strobe = 6'(t); cfg_rd_hold = 3'(h);
               cfg_wr_setup = 4'd5;  cfg_wr_strobe = 6'd7;  cfg_wr_hold = 3'd6;
               run_access(1'b0, AW'(s*97 + t*13 + h), 4'(s+t+h), 32'h0,
                          eff(s), eff(t), eff(h), 0, "R5 read sweep");
            end
      // write sweep, read fields set to distinct values
      for (int s = 0; s < 4; s++)
         for (int t = 0; t < 4; t++)
            for (int h = 0; h < 4; h++) begin
               cfg_wr_setup = 4'(s); cfg_wr_strobe = 6'(t); cfg_wr_hold = 3'(h);
               cfg_rd_setup = 4'd6;  cfg_rd_strobe = 6'd9;  cfg_rd_hold = 3'd5;
               run_access(1'b1, AW'(20'hF0000 + s*31 + t*7 + h), 4'(15 - h),
                          32'h1234_0000 + 32'(s*64 + t*8 + h),
                          eff(s), eff(t), eff(h), 0, "R5 write sweep");
            end

      // maximum field values
      cfg_rd_setup = 4'd15; cfg_rd_strobe = 6'd63; cfg_rd_hold = 3'd7;
      run_access(1'b0, 20'hABCDE, 4'hF, 32'h0, 15, 63, 7, 0, "R3 read max");

      // R8: ready stretches strobe; expected max(T', j+2)
      cfg_rd_setup = 4'd1; cfg_rd_strobe = 6'd1; cfg_rd_hold = 3'd1;
      run_access(1'b0, 20'h00321, 4'h3, 32'h0, 1, 5, 1, 3, "R8 read rdy j=3");
      cfg_wr_setup = 4'd2; cfg_wr_strobe = 6'd4; cfg_wr_hold = 3'd1;
      run_access(1'b1, 20'h00777, 4'h9, 32'hCAFE_F00D, 2, 4, 1, 1, "R8 write rdy j=1");
      cfg_wr_strobe = 6'd2;
      run_access(1'b1, 20'h01234, 4'h6, 32'h5555_AAAA, 2, 7, 1, 5, "R8 write rdy j=5");
      cfg_rd_setup = 4'd2; cfg_rd_strobe = 6'd3; cfg_rd_hold = 3'd2;
      run_access(1'b0, 20'h3C3C3, 4'hC, 32'h0, 2, 6, 2, 4, "R8 R9 read rdy j=4");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule